// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block is a data cache that sits between a processor request port and a main-memory block port. Each byte address is cut into a tag, a line index and a byte offset. The index picks exactly one line. A request hits when that line is valid and holds the same tag. A hit is answered at once from the line. A miss stalls the processor while the line is refilled from memory. The request is then served from the cache.

Stores write only into the cache and mark the line modified. A modified line goes back to memory only when another block evicts it. That write-back always runs before the refill read. A store miss allocates: the block is fetched first, then the enabled bytes are merged into it.

The processor holds a request, with all of its fields, until `cpu_ready` is high at a clock edge. The memory side holds a request until `mem_ack` pulses. The line count is a parameter. The default of 16 lines keeps simulation small, and the field order stays the same at any size.

Top module: `dm_wb_cache`

## Requirements
- R1: The tag is `cpu_addr[ADDR_W-1:IDX_W+2]`, the line index is `cpu_addr[IDX_W+1:2]` and the byte offset is `cpu_addr[1:0]`. The offset plays no part in hit detection. The memory port addresses whole blocks: a refill reads block number `cpu_addr[ADDR_W-1:2]`.
- R2: On a hit (indexed line valid and stored tag equal to the address tag), `cpu_ready` is high in the same cycle as `cpu_req`, with no wait state. `cpu_rdata` then carries the 32-bit line.
- R3: On a miss, `cpu_ready` stays low until the refill read has been acknowledged. The request is served in the cycle after that acknowledge, with the data just fetched.
- R4: Reset clears every valid bit, so the first access to any line after reset is a miss.
- R5: A store hit updates only the cache: no memory request follows it. Bit i of `cpu_be` enables byte `cpu_wdata[8i+7:8i]`, and disabled bytes keep their old value.
- R6: A store miss first fetches the block from memory, then merges the enabled bytes. The line is modified afterwards.
- R7: When a modified line is evicted, its old contents are written to memory at block `{old tag, index}` before the refill read is issued. Both run on the same request.
- R8: Evicting an unmodified line issues no memory write: only the refill read appears.
- R9: A memory request keeps `mem_req`, `mem_we` and `mem_addr` stable until the cycle in which `mem_ack` is high.
- R10: Blocks with different line indices stay resident together. A block that another index has not displaced still hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until served |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_be | input | 4 | Byte enables for a store |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data (indexed line) |
| cpu_ready | output | 1 | Request served this cycle |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write-back, 0 = refill read |
| mem_addr | output | ADDR_W-2 | Block number |
| mem_wdata | output | 32 | Write-back data |
| mem_rdata | input | 32 | Refill data, valid with mem_ack |
| mem_ack | input | 1 | One-cycle acknowledge |

## Verification
A wrong tag, valid or modified bit shows at the ports within one request. A line that should hit shows wait states, or one that should miss answers at once. A lost or spurious modified bit changes the memory traffic on the next conflicting miss: a write-back goes missing or appears, or comes after the refill read. Corrupted line data reaches `cpu_rdata` on the next load to that index. A lost write-back appears as stale data once the block is fetched again.

// File: rtl/dm_wb_cache.sv
module dm_wb_cache #(
  parameter int ADDR_W = 24,
  parameter int IDX_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cpu_req,
  input  logic                            cpu_we,
  input  logic [ADDR_W-1:0]               cpu_addr,
  input  logic [DATA_W/8-1:0]             cpu_be,
  input  logic [DATA_W-1:0]               cpu_wdata,
  output logic [DATA_W-1:0]               cpu_rdata,
  output logic                            cpu_ready,
  output logic                            mem_req,
  output logic                            mem_we,
  output logic [ADDR_W-$clog2(DATA_W/8)-1:0] mem_addr,
  output logic [DATA_W-1:0]               mem_wdata,
  input  logic [DATA_W-1:0]               mem_rdata,
  input  logic                            mem_ack
);
  localparam int NBYTE = DATA_W / 8;
  localparam int OFF_W = $clog2(NBYTE);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
  localparam int LINES = 1 << IDX_W;

  typedef enum logic [1:0] {S_IDLE, S_WB, S_FILL} st_t;
  st_t st;

  logic [LINES-1:0] valid_q, dirty_q;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  wire [IDX_W-1:0] idx = cpu_addr[OFF_W +: IDX_W];
  wire [TAG_W-1:0] tag = cpu_addr[ADDR_W-1 -: TAG_W];
  wire unused_off = ^cpu_addr[OFF_W-1:0];
  wire hit = valid_q[idx] && (tag_q[idx] == tag);

  assign cpu_ready = (st == S_IDLE) && cpu_req && hit;
  assign cpu_rdata = data_q[idx];
  assign mem_req   = (st != S_IDLE);
  assign mem_we    = (st == S_WB);
  assign mem_addr  = (st == S_WB) ? {tag_q[idx], idx} : {tag, idx};
  assign mem_wdata = data_q[idx];

  logic [DATA_W-1:0] merged;
  always_comb begin
    merged = data_q[idx];
    for (int i = 0; i < NBYTE; i++)
      if (cpu_be[i]) merged[8*i +: 8] = cpu_wdata[8*i +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (cpu_ready && cpu_we) dirty_q[idx] <= 1'b1;
          if (cpu_req && !hit)
            st <= (valid_q[idx] && dirty_q[idx]) ? S_WB : S_FILL;
        end
        S_WB:   if (mem_ack) st <= S_FILL;
        S_FILL: if (mem_ack) begin
          valid_q[idx] <= 1'b1;
          dirty_q[idx] <= 1'b0;
          st           <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (cpu_ready && cpu_we) data_q[idx] <= merged;
    if (st == S_FILL && mem_ack) begin
      data_q[idx] <= mem_rdata;
      tag_q[idx]  <= tag;
    end
  end

  // R2
  ready_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> cpu_req && !mem_req);

  // R3
  serve_after_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_ack && cpu_req) |=> cpu_ready);

  // R5
  store_hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && cpu_we) |=> !mem_req);

  // R7
  wb_then_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_ack) |=> mem_req && !mem_we);

  // R9
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr) && $stable(mem_we));
endmodule

// File: tb/dm_wb_cache_test.sv
module dm_wb_cache_test;
  localparam int AW = 24;
  localparam int BW = AW - 2;

  logic clk = 0, rst_n = 0;
  logic cpu_req = 0, cpu_we = 0;
  logic [AW-1:0] cpu_addr = '0;
  logic [3:0] cpu_be = '0;
  logic [31:0] cpu_wdata = '0, cpu_rdata;
  logic cpu_ready, mem_req, mem_we, mem_ack = 0;
  logic [BW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata = '0;

  dm_wb_cache uut (.clk, .rst_n, .cpu_req, .cpu_we, .cpu_addr, .cpu_be, .cpu_wdata,
    .cpu_rdata, .cpu_ready, .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_rdata, .mem_ack);

  always #2.5 clk = ~clk;

  int total = 0, bad = 0, wr_cnt = 0;
  bit done = 0;
  logic [31:0] bk   [logic [BW-1:0]];
  logic [31:0] gold [logic [BW-1:0]];
  logic [31:0] exp_q [$];
  logic op_we_q [$];
  logic [BW-1:0] op_addr_q [$];
  int mcnt = 0;

  function automatic logic [31:0] init_word(logic [BW-1:0] b);
    return {b[21:0], 10'h2c3};
  endfunction
  function automatic logic [31:0] bk_rd(logic [BW-1:0] b);
    return bk.exists(b) ? bk[b] : init_word(b);
  endfunction
  function automatic logic [31:0] gold_rd(logic [BW-1:0] b);
    return gold.exists(b) ? gold[b] : init_word(b);
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory responder: acknowledge two cycles after a request appears
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack <= 0;
      mcnt = 0;
    end else if (mem_req) begin
      mcnt++;
      if (mcnt == 2) begin
        mem_ack <= 1;
        op_we_q.push_back(mem_we);
        op_addr_q.push_back(mem_addr);
        if (mem_we) begin
          bk[mem_addr] = mem_wdata;
          wr_cnt++;
        end else mem_rdata <= bk_rd(mem_addr);
      end
    end
  end

  // monitor: compare each served load against the scoreboard
  always @(negedge clk) begin
    #1;
    if (rst_n && cpu_req && cpu_ready && !cpu_we) begin
      if (exp_q.size() == 0) chk(0, "R2 unexpected load", cpu_rdata, 32'h0);
      else begin
        automatic logic [31:0] e = exp_q.pop_front();
        chk(cpu_rdata == e, "R2/R3/R5/R6 load data", cpu_rdata, e);
      end
    end
  end

  task automatic access(bit we, logic [AW-1:0] a, logic [3:0] be, logic [31:0] wd,
                        output int waits);
    logic [BW-1:0] b = a[AW-1:2];
    waits = 0;
    op_we_q.delete();
    op_addr_q.delete();
    if (we) begin
      automatic logic [31:0] v = gold_rd(b);
      for (int i = 0; i < 4; i++) if (be[i]) v[8*i +: 8] = wd[8*i +: 8];
      gold[b] = v;
    end else exp_q.push_back(gold_rd(b));
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_be = be; cpu_wdata = wd;
    #0.5;
    while (!cpu_ready) begin
      waits++;
      @(negedge clk);
      #0.5;
    end
    @(posedge clk);
    @(negedge clk);
    cpu_req = 0; cpu_we = 0;
  endtask

  initial begin
    #500000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  localparam logic [AW-1:0] A = 24'h000104, B = 24'h000204, C = 24'h000108, D = 24'h000304;

  initial begin
    int w, wc;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!cpu_ready && !mem_req, "R4 reset idle", {30'b0, cpu_ready, mem_req}, 32'h0);
    rst_n = 1;

    access(0, A, 4'h0, 0, w);                                  // R4, R3
    chk(w > 0, "R4 first access misses", w, 1);
    chk(op_we_q.size() == 1 && op_we_q[0] == 0, "R3 single refill read", op_we_q.size(), 1);
    chk(op_addr_q.size() == 1 && op_addr_q[0] == A[AW-1:2], "R1 block address", op_addr_q[0], A[AW-1:2]);

    access(0, A, 4'h0, 0, w);
    chk(w == 0, "R2 hit no wait", w, 0);
    access(0, A | 24'h3, 4'h0, 0, w);
    chk(w == 0, "R1 offset ignored on hit", w, 0);

    wc = wr_cnt;
    access(1, A, 4'b0101, 32'hDEADBEEF, w);
    chk(w == 0 && op_we_q.size() == 0, "R5 store hit no traffic", op_we_q.size(), 0);
    chk(wr_cnt == wc, "R5 no memory write", wr_cnt, wc);
    access(0, A, 4'h0, 0, w);                                  // R5 merged bytes

    access(0, C, 4'h0, 0, w);
    chk(w > 0, "R10 other index miss", w, 1);
    access(0, A, 4'h0, 0, w);
    chk(w == 0, "R10 first line still resident", w, 0);

    access(0, B, 4'h0, 0, w);                                  // R7
    chk(op_we_q.size() == 2 && op_we_q[0] == 1 && op_we_q[1] == 0,
        "R7 write-back before refill", op_we_q.size(), 2);
    chk(op_addr_q.size() == 2 && op_addr_q[0] == A[AW-1:2], "R7 write-back address",
        op_addr_q[0], A[AW-1:2]);
    chk(bk_rd(A[AW-1:2]) == gold_rd(A[AW-1:2]), "R7 written data",
        bk_rd(A[AW-1:2]), gold_rd(A[AW-1:2]));

    wc = wr_cnt;
    access(0, A, 4'h0, 0, w);                                  // R8
    chk(op_we_q.size() == 1 && op_we_q[0] == 0, "R8 clean eviction read only", op_we_q.size(), 1);
    chk(wr_cnt == wc, "R8 no write", wr_cnt, wc);

    access(1, D, 4'b1100, 32'hCAFE1234, w);                    // R6
    chk(w > 0 && op_we_q.size() == 1 && op_we_q[0] == 0, "R6 store miss fetch", op_we_q.size(), 1);
    access(0, D, 4'h0, 0, w);
    chk(w == 0, "R6 allocated line hits", w, 0);
    access(0, A, 4'h0, 0, w);
    chk(op_we_q.size() == 2 && op_we_q[0] == 1, "R6 allocated line modified", op_we_q.size(), 2);
    chk(bk_rd(D[AW-1:2]) == gold_rd(D[AW-1:2]), "R6 merged data written back",
        bk_rd(D[AW-1:2]), gold_rd(D[AW-1:2]));

    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R2 all loads served", exp_q.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule